// File: doc/BRIEF.md
# I/O Register Space with Single-Bit Clear

This block holds a bank of 64 eight-bit I/O registers next to a file of 32 eight-bit general registers and moves data between them one operation at a time. The operations arrive already decoded: a general register can be loaded from any I/O register, any I/O register can be written from a general register, and a general register can be seeded with an immediate byte. A fourth operation clears a single bit of an I/O register. It is presented as the raw 16-bit instruction word, and the block decodes that word itself. Because the word carries only a 5-bit register field next to its 3-bit bit index, the clear can reach only the lower 32 I/O registers.

Operations enter on a valid/ready stream. A transfer takes place on a rising clock edge where `op_valid` and `op_ready` are both high. `op_ready` is held low while reset is asserted and stays high from the first edge after release, so the block never pushes back on an operation in normal running. The payload fields are ignored in any cycle without a transfer. Every accepted operation completes on the edge that accepts it. Two debug ports read either register space combinationally at any time.

Top module: `ioxp_top`

## Requirements
- R1: While `rst_n` is low, `op_ready` is low and every I/O and general register reads 0 on the debug ports. From the first rising edge after release, `op_ready` stays high.
- R2: Kind 3 (load) writes `op_word[7:0]` into general register `op_gpr`.
- R3: Kind 0 (input) copies I/O register `op_ioaddr` (0 to 63) into general register `op_gpr` (0 to 31).
- R4: Kind 1 (output) copies general register `op_gpr` into I/O register `op_ioaddr`, for every one of the 64 addresses.
- R5: Kind 2 (bit clear) takes `op_word` = 10011000AAAAAbbb, with the register A in bits 7:3 and the bit index b in bits 2:0. It clears bit b of I/O register A and leaves the other seven bits unchanged.
- R6: A bit clear never writes I/O registers 32 to 63, and it ignores `op_ioaddr` and `op_gpr`.
- R7: A kind-2 operation whose `op_word[15:8]` differs from 8'b10011000 changes no register.
- R8: A cycle without a transfer changes no register. An accepted operation writes exactly one register, in exactly one of the two spaces.
- R9: The debug ports are combinational. In the cycle an operation writes a register they still show the old value, and from the next cycle they show the new one. An operation issued in the very next cycle sees the result of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Operation can be accepted |
| op_kind | input | 2 | 0 input, 1 output, 2 bit clear, 3 load immediate |
| op_gpr | input | 5 | General register number for kinds 0, 1, 3 |
| op_ioaddr | input | 6 | I/O register address for kinds 0, 1 |
| op_word | input | 16 | Raw bit-clear word (kind 2) or immediate in bits 7:0 (kind 3) |
| dbg_io_addr | input | 6 | Debug read address, I/O space |
| dbg_io_data | output | 8 | Debug read data, I/O space |
| dbg_gpr_addr | input | 5 | Debug read address, general registers |
| dbg_gpr_data | output | 8 | Debug read data, general registers |

## Verification
A debug read of a register and a write to that same register by an output or bit-clear operation can fall in the same cycle. The bench provokes this by aiming the debug address at the target while the operation is still valid, before the accepting edge. The old value is expected then, and the new value once the edge has passed. Two operations on one register can also follow each other with no gap: an output or bit clear immediately followed by an input of the same register. This pairing is judged by whether the general register ends up holding the freshly written value.

// File: rtl/ioxp_pkg.sv
package ioxp_pkg;
  typedef enum logic [1:0] {
    OPK_IN    = 2'd0,
    OPK_OUT   = 2'd1,
    OPK_CLR   = 2'd2,
    OPK_LOAD  = 2'd3
  } op_kind_e;
endpackage

// File: rtl/ioxp_regbank.sv
module ioxp_regbank #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DEPTH*DW-1:0] flat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (we && (waddr == AW'(i)))    q <= wdata;
    end
    assign flat[i*DW +: DW] = q;
  end

  assign rdata_a = flat[raddr_a*DW +: DW];
  assign rdata_b = flat[raddr_b*DW +: DW];
endmodule

// File: rtl/ioxp_decode.sv
module ioxp_decode
  import ioxp_pkg::*;
#(
  parameter int unsigned IO_AW      = 6,
  parameter int unsigned GPR_AW     = 5,
  parameter int unsigned BIT_W      = 3,
  parameter int unsigned IW         = 16,
  parameter int unsigned CLR_OPCODE = 'h98,
  localparam int unsigned CLR_AW    = IO_AW - 1,
  localparam int unsigned OPC_W     = IW - CLR_AW - BIT_W
) (
  input  logic              fire,
  input  logic [1:0]        kind,
  input  logic [GPR_AW-1:0] gpr,
  input  logic [IO_AW-1:0]  ioaddr,
  input  logic [IW-1:0]     word,
  output logic              io_we,
  output logic [IO_AW-1:0]  io_addr,
  output logic              io_from_clr,
  output logic [BIT_W-1:0]  clr_bit,
  output logic              gpr_we,
  output logic [GPR_AW-1:0] gpr_addr,
  output logic              gpr_from_io
);
  logic [OPC_W-1:0]  opc;
  logic [CLR_AW-1:0] clr_reg;
  logic              opc_hit;

  assign opc     = word[IW-1 -: OPC_W];
  assign clr_reg = word[BIT_W +: CLR_AW];
  assign clr_bit = word[BIT_W-1:0];
  assign opc_hit = (opc == OPC_W'(CLR_OPCODE));

  always_comb begin
    io_we       = 1'b0;
    io_addr     = ioaddr;
    io_from_clr = 1'b0;
    gpr_we      = 1'b0;
    gpr_addr    = gpr;
    gpr_from_io = 1'b0;
    unique case (op_kind_e'(kind))
      OPK_IN: begin
        gpr_we      = fire;
        gpr_from_io = 1'b1;
      end
      OPK_OUT: io_we = fire;
      OPK_CLR: begin
        io_addr     = {1'b0, clr_reg};
        io_from_clr = 1'b1;
        io_we       = fire && opc_hit;
      end
      OPK_LOAD: gpr_we = fire;
      default: ;
    endcase
  end
endmodule

// File: rtl/ioxp_clrmask.sv
module ioxp_clrmask #(
  parameter int unsigned DW   = 8,
  localparam int unsigned BW  = $clog2(DW)
) (
  input  logic [DW-1:0] din,
  input  logic [BW-1:0] sel,
  output logic [DW-1:0] dout
);
  for (genvar k = 0; k < DW; k++) begin : g_bit
    assign dout[k] = din[k] & (sel != BW'(k));
  end
endmodule

// File: rtl/ioxp_top.sv
module ioxp_top
  import ioxp_pkg::*;
#(
  parameter int unsigned IO_DEPTH   = 64,
  parameter int unsigned GPR_DEPTH  = 32,
  parameter int unsigned DW         = 8,
  parameter int unsigned IW         = 16,
  parameter int unsigned CLR_OPCODE = 'h98,
  localparam int unsigned IO_AW     = $clog2(IO_DEPTH),
  localparam int unsigned GPR_AW    = $clog2(GPR_DEPTH),
  localparam int unsigned BIT_W     = $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_kind,
  input  logic [GPR_AW-1:0] op_gpr,
  input  logic [IO_AW-1:0]  op_ioaddr,
  input  logic [IW-1:0]     op_word,
  input  logic [IO_AW-1:0]  dbg_io_addr,
  output logic [DW-1:0]     dbg_io_data,
  input  logic [GPR_AW-1:0] dbg_gpr_addr,
  output logic [DW-1:0]     dbg_gpr_data
);
  logic              ready_q;
  logic              fire;
  logic              io_we, io_from_clr, gpr_we, gpr_from_io;
  logic [IO_AW-1:0]  io_addr;
  logic [GPR_AW-1:0] gpr_addr;
  logic [BIT_W-1:0]  clr_bit;
  logic [DW-1:0]     io_rdata, io_wdata, io_cleared;
  logic [DW-1:0]     gpr_rdata, gpr_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign op_ready = ready_q;
  assign fire     = op_valid && ready_q;

  ioxp_decode #(
    .IO_AW(IO_AW), .GPR_AW(GPR_AW), .BIT_W(BIT_W), .IW(IW), .CLR_OPCODE(CLR_OPCODE)
  ) u_dec (
    .fire(fire), .kind(op_kind), .gpr(op_gpr), .ioaddr(op_ioaddr), .word(op_word),
    .io_we(io_we), .io_addr(io_addr), .io_from_clr(io_from_clr), .clr_bit(clr_bit),
    .gpr_we(gpr_we), .gpr_addr(gpr_addr), .gpr_from_io(gpr_from_io)
  );

  ioxp_clrmask #(.DW(DW)) u_clr (.din(io_rdata), .sel(clr_bit), .dout(io_cleared));

  assign io_wdata  = io_from_clr ? io_cleared : gpr_rdata;
  assign gpr_wdata = gpr_from_io ? io_rdata : op_word[DW-1:0];

  ioxp_regbank #(.DEPTH(IO_DEPTH), .DW(DW)) u_io (
    .clk(clk), .rst_n(rst_n), .we(io_we), .waddr(io_addr), .wdata(io_wdata),
    .raddr_a(io_addr), .rdata_a(io_rdata),
    .raddr_b(dbg_io_addr), .rdata_b(dbg_io_data)
  );

  ioxp_regbank #(.DEPTH(GPR_DEPTH), .DW(DW)) u_gpr (
    .clk(clk), .rst_n(rst_n), .we(gpr_we), .waddr(gpr_addr), .wdata(gpr_wdata),
    .raddr_a(gpr_addr), .rdata_a(gpr_rdata),
    .raddr_b(dbg_gpr_addr), .rdata_b(dbg_gpr_data)
  );
endmodule

// File: rtl/ioxp_chk.sv
module ioxp_chk #(
  parameter int unsigned IO_AW      = 6,
  parameter int unsigned DW         = 8,
  parameter int unsigned IW         = 16,
  parameter int unsigned CLR_OPCODE = 'h98,
  localparam int unsigned OPC_W     = IW - (IO_AW - 1) - $clog2(DW)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             op_ready,
  input logic [1:0]       op_kind,
  input logic [IW-1:0]    op_word,
  input logic             io_we,
  input logic [IO_AW-1:0] io_addr,
  input logic             io_from_clr,
  input logic [DW-1:0]    io_rdata,
  input logic [DW-1:0]    io_wdata,
  input logic             gpr_we
);
  logic bad_clr;
  assign bad_clr = op_valid && op_ready && (op_kind == 2'd2) &&
                   (op_word[IW-1 -: OPC_W] != OPC_W'(CLR_OPCODE));

  AST_RDY_LOW_IN_RESET: assert property (@(posedge clk)
    (!rst_n && $past(!rst_n)) |-> !op_ready);  // R1

  AST_CLR_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_from_clr) |-> !io_addr[IO_AW-1]);  // R6

  AST_CLR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_from_clr) |->
      (($countones(io_rdata ^ io_wdata) <= 1) && ((io_wdata & ~io_rdata) == '0)));  // R5

  AST_CLR_BAD_OPC: assert property (@(posedge clk) disable iff (!rst_n)
    bad_clr |-> !io_we);  // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_ready) |-> (!io_we && !gpr_we));  // R8

  AST_ONE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_we && gpr_we));  // R8
endmodule

bind ioxp_top ioxp_chk #(
  .IO_AW(IO_AW), .DW(DW), .IW(IW), .CLR_OPCODE(CLR_OPCODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_kind(op_kind), .op_word(op_word), .io_we(io_we), .io_addr(io_addr),
  .io_from_clr(io_from_clr), .io_rdata(io_rdata), .io_wdata(io_wdata),
  .gpr_we(gpr_we)
);

// File: tb/tb_ioxp_top.sv
`timescale 1ns/1ps
module tb_ioxp_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_kind = 2'd0;
  logic [4:0]  op_gpr = '0;
  logic [5:0]  op_ioaddr = '0;
  logic [15:0] op_word = '0;
  logic [5:0]  dbg_io_addr = '0;
  logic [7:0]  dbg_io_data;
  logic [4:0]  dbg_gpr_addr = '0;
  logic [7:0]  dbg_gpr_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] io_m [64];
  logic [7:0] gpr_m [32];

  always #4 clk = ~clk;

  ioxp_top dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_gpr(op_gpr), .op_ioaddr(op_ioaddr), .op_word(op_word),
    .dbg_io_addr(dbg_io_addr), .dbg_io_data(dbg_io_data),
    .dbg_gpr_addr(dbg_gpr_addr), .dbg_gpr_data(dbg_gpr_data)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic see_io(input int a, input string tag);
    dbg_io_addr = 6'(a);
    #1;
    chk(dbg_io_data === io_m[a], tag, int'(dbg_io_data), int'(io_m[a]));
  endtask

  task automatic see_gpr(input int g, input string tag);
    dbg_gpr_addr = 5'(g);
    #1;
    chk(dbg_gpr_data === gpr_m[g], tag, int'(dbg_gpr_data), int'(gpr_m[g]));
  endtask

  task automatic issue(input logic [1:0] k, input int g, input int a, input logic [15:0] w);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_gpr = 5'(g); op_ioaddr = 6'(a); op_word = w;
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  function automatic logic [15:0] clr_word(input int a, input int b);
    return {8'h98, 5'(a), 3'(b)};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 64; i++) io_m[i] = 8'h00;
    for (int i = 0; i < 32; i++) gpr_m[i] = 8'h00;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(op_ready === 1'b0, "R1 ready in reset", int'(op_ready), 0);
    for (int a = 0; a < 64; a++) see_io(a, "R1 io reset");
    for (int g = 0; g < 32; g++) see_gpr(g, "R1 gpr reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(op_ready === 1'b1, "R1 ready after release", int'(op_ready), 1);

    // R2: load immediates into every general register
    for (int g = 0; g < 32; g++) begin
      gpr_m[g] = 8'((g * 37 + 11) ^ 8'h5A);
      issue(2'd3, g, 63 - g, {8'hFF, gpr_m[g]});
    end
    idle();
    for (int g = 0; g < 32; g++) see_gpr(g, "R2 load");

    // R4: output to all 64 I/O registers
    for (int a = 0; a < 64; a++) begin
      io_m[a] = gpr_m[(a * 5 + 3) % 32];
      issue(2'd1, (a * 5 + 3) % 32, a, 16'h0000);
    end
    idle();
    for (int a = 0; a < 64; a++) see_io(a, "R4 output");

    // R3: input from the upper and lower halves
    for (int g = 0; g < 32; g++) begin
      gpr_m[g] = io_m[(g % 2 == 0) ? 63 - g : g];
      issue(2'd0, g, (g % 2 == 0) ? 63 - g : g, 16'h0000);
    end
    idle();
    for (int g = 0; g < 32; g++) see_gpr(g, "R3 input");

    // R5/R6: clear each bit of each low register starting from all ones
    gpr_m[0] = 8'hFF;
    issue(2'd3, 0, 0, 16'h00FF);
    for (int a = 0; a < 32; a++) begin
      io_m[a] = 8'hFF;
      issue(2'd1, 0, a, 16'h0000);
    end
    idle();
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 8; b++) begin
        io_m[a] = io_m[a] & ~(8'(1) << b);
        issue(2'd2, 31 - a, a + 32, clr_word(a, b));  // op_ioaddr points high, must be ignored
        idle();
        see_io(a, "R5 bit clear");
      end
    end
    for (int a = 32; a < 64; a++) see_io(a, "R6 upper half untouched");
    for (int g = 0; g < 32; g++) see_gpr(g, "R6 gprs untouched");

    // partial clear: other bits intact on a mixed value
    gpr_m[1] = 8'hB6;
    issue(2'd3, 1, 0, 16'h00B6);
    io_m[9] = 8'hB6;
    issue(2'd1, 1, 9, 16'h0000);
    io_m[9] = 8'hB6 & ~8'h04;
    issue(2'd2, 0, 0, clr_word(9, 2));
    io_m[9] = io_m[9] & ~8'h80;
    issue(2'd2, 0, 0, clr_word(9, 7));
    issue(2'd2, 0, 0, clr_word(9, 0));   // bit 0 already clear
    idle();
    see_io(9, "R5 mixed value clear");

    // R7: corrupted opcode byte on a register holding all ones
    gpr_m[2] = 8'hFF;
    issue(2'd3, 2, 0, 16'h00FF);
    io_m[3] = 8'hFF;
    issue(2'd1, 2, 3, 16'h0000);
    for (int k = 0; k < 8; k++) begin
      issue(2'd2, 0, 0, {8'h98 ^ (8'(1) << k), 5'd3, 3'(k)});
      idle();
      see_io(3, "R7 bad opcode ignored");
    end

    // R8: payload without valid
    @(negedge clk);
    op_valid = 1'b0; op_kind = 2'd1; op_gpr = 5'd2; op_ioaddr = 6'd40; op_word = 16'h00FF;
    @(negedge clk);
    op_kind = 2'd3; op_gpr = 5'd7;
    @(negedge clk);
    see_io(40, "R8 no valid, io");
    see_gpr(7, "R8 no valid, gpr");

    // R9: same-cycle debug read returns old, next cycle new
    issue(2'd1, 2, 45, 16'h0000);
    see_io(45, "R9 old value during write");
    io_m[45] = gpr_m[2];
    idle();
    see_io(45, "R9 new value after write");
    issue(2'd2, 0, 0, clr_word(3, 5));
    see_io(3, "R9 old value during clear");
    io_m[3] = io_m[3] & ~8'h20;
    idle();
    see_io(3, "R9 new value after clear");

    // R9: back-to-back output then input of the same register
    issue(2'd1, 1, 20, 16'h0000);
    io_m[20] = gpr_m[1];
    issue(2'd0, 4, 20, 16'h0000);
    gpr_m[4] = io_m[20];
    idle();
    see_gpr(4, "R9 output then input");
    issue(2'd2, 0, 0, clr_word(20, 1));
    io_m[20] = io_m[20] & ~8'h02;
    issue(2'd0, 5, 20, 16'h0000);
    gpr_m[5] = io_m[20];
    idle();
    see_gpr(5, "R9 clear then input");
    see_io(20, "R9 clear result");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule